// File: doc/BRIEF.md
# Butterfly Destination-Tag Packet Router

This block is a multistage switching fabric that moves single-beat packets from any of its input columns to the output column named in the packet's destination field. It is built as log2(NPORTS) ranks of 2x2 switching elements. In rank s, column j is paired with the column whose index differs from j only in bit position log2(NPORTS)-1-s, which is the s-th bit counted from the most significant end. Each element looks at the leading bit of the destination field it receives and forwards the packet toward the column in which that index bit matches. It then drops the bit it has used, so the next rank sees a header that is one bit shorter.

A packet carries a destination header that is log2(NPORTS) bits wide at entry, a 16-bit payload word and an 8-bit checksum trailer. The fabric moves the trailer along with the payload and does not inspect it. Every input column and every output column has a valid/ready handshake. When both inputs of an element want the same output in the same cycle, the upper input wins and the lower input is held back. Each element registers its outputs once, so an unobstructed packet crosses the fabric in exactly log2(NPORTS) cycles.

Top module: `bfly_router`

## Requirements
- R1: While rst_n is low, and after reset until a packet has been accepted, every bit of out_valid is 0.
- R2: A packet accepted on any input column with destination d leaves exactly once, with its payload and checksum bit-for-bit unchanged, and no accepted packet is lost.
- R3: A packet accepted in cycle t that meets no contention and no backpressure raises out_valid in cycle t+log2(NPORTS), which is t+3 at the default size.
- R4: Each rank steers on the most significant remaining header bit. A 0 goes to the lower-numbered column of the pair and a 1 goes to the higher-numbered one. The used bit is then shifted out. The packet therefore exits on out port d, where d is the original destination, and no header bits remain at exit.
- R5: In the first rank, column j is paired with column j+NPORTS/2. If both columns are valid in the same cycle with the same destination MSB, in_ready is high for column j and low for column j+NPORTS/2. The losing packet is accepted one cycle later and exits one cycle after the winner.
- R6: If the two inputs of a pair have different destination MSBs, both are accepted in the same cycle and both meet the R3 latency.
- R7: While out_valid[k] is high and out_ready[k] is low, out_valid[k], the payload and the checksum on port k stay constant.
- R8: The checksum trailer is not checked. A packet whose trailer does not equal the modulo-256 sum of its two payload bytes is delivered unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | NPORTS | Per input column: a packet is offered |
| in_ready | output | NPORTS | Per input column: the fabric takes the offered packet this cycle |
| in_dest | input | NPORTS*log2(NPORTS) | Destination header per column, column p at bits [p*log2(NPORTS) +: log2(NPORTS)] |
| in_payload | input | NPORTS*16 | Payload word per column |
| in_csum | input | NPORTS*8 | Checksum trailer per column |
| out_valid | output | NPORTS | Per output column: a packet is presented |
| out_ready | input | NPORTS | Per output column: the sink takes the packet |
| out_payload | output | NPORTS*16 | Payload word per output column |
| out_csum | output | NPORTS*8 | Checksum trailer per output column |

## Verification
Lone packets are sent for all 64 source and destination pairs, one at a time. This separates a wrong pairing of columns or a wrong steering bit in any rank from a wrong register count. Two directed pairs on the same first-rank element are then offered. In one pair both packets want the same output; in the other they want different outputs. Together they show whether priority goes to the upper input and whether a false conflict stalls traffic that could proceed. A stalled output column and a corrupted trailer show that data is held under backpressure and that the trailer passes through as opaque data. Dense random traffic with random sink stalls then looks for losses and duplicates when every column is busy.

// File: rtl/bfly_pkg.sv
// Shared widths and packet body type for the butterfly router.
// Assumes a single-beat packet: header travels beside the body.
package bfly_pkg;
    localparam int PAY_W = 16;
    localparam int SUM_W = 8;

    typedef struct packed {
        logic [PAY_W-1:0] pay;
        logic [SUM_W-1:0] sum;
    } flit_body_t;
endpackage

// File: rtl/bfly_switch.sv
// 2x2 switching element with one output register per direction.
// Steers on the header MSB (0 -> out0, 1 -> out1), shifts that bit out,
// and gives the upper input (a) fixed priority over the lower input (b).
// Assumes in-order valid/ready on every side; ready may depend on valid.
module bfly_switch
    import bfly_pkg::*;
#(
    parameter int HW = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   a_vld,
    output logic                   a_rdy,
    input  logic [HW-1:0]          a_hdr,
    input  flit_body_t             a_body,
    input  logic                   b_vld,
    output logic                   b_rdy,
    input  logic [HW-1:0]          b_hdr,
    input  flit_body_t             b_body,
    output logic [1:0]             o_vld,
    input  logic [1:0]             o_rdy,
    output logic [1:0][HW-1:0]     o_hdr,
    output flit_body_t [1:0]       o_body
);
    logic       a_dir;
    logic       b_dir;
    logic [1:0] slot_free;
    logic       b_blocked;
    logic       a_take;
    logic       b_take;

    // Direction decode, free slots and priority between the two inputs.
    always_comb begin
        a_dir     = a_hdr[HW-1];
        b_dir     = b_hdr[HW-1];
        slot_free = ~o_vld | o_rdy;
        b_blocked = a_vld && (a_dir == b_dir);
        a_rdy     = slot_free[a_dir];
        b_rdy     = slot_free[b_dir] && !b_blocked;
        a_take    = a_vld && a_rdy;
        b_take    = b_vld && b_rdy;
    end

    for (genvar o = 0; o < 2; o++) begin : g_out
        // Output register o: load the winning input or drain when taken.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                o_vld[o]  <= 1'b0;
                o_hdr[o]  <= '0;
                o_body[o] <= '0;
            end else if (a_take && (a_dir == 1'(o))) begin
                o_vld[o]  <= 1'b1;
                o_hdr[o]  <= a_hdr << 1;
                o_body[o] <= a_body;
            end else if (b_take && (b_dir == 1'(o))) begin
                o_vld[o]  <= 1'b1;
                o_hdr[o]  <= b_hdr << 1;
                o_body[o] <= b_body;
            end else if (o_rdy[o]) begin
                o_vld[o]  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/bfly_rank.sv
// One rank of N/2 switching elements. Rank STG pairs column j with the
// column that differs in index bit LOGN-1-STG; the lower-numbered column of
// the pair is the upper (priority) input and receives direction 0.
module bfly_rank
    import bfly_pkg::*;
#(
    parameter int N    = 8,
    parameter int LOGN = 3,
    parameter int STG  = 0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N-1:0]               vld_i,
    output logic [N-1:0]               rdy_o,
    input  logic [N-1:0][LOGN-1:0]     hdr_i,
    input  flit_body_t [N-1:0]         body_i,
    output logic [N-1:0]               vld_o,
    input  logic [N-1:0]               rdy_i,
    output logic [N-1:0][LOGN-1:0]     hdr_o,
    output flit_body_t [N-1:0]         body_o
);
    localparam int BIT = LOGN - 1 - STG;

    for (genvar p = 0; p < N / 2; p++) begin : g_pair
        localparam int UP = ((p >> BIT) << (BIT + 1)) | (p & ((1 << BIT) - 1));
        localparam int LO = UP | (1 << BIT);

        logic [1:0]           pv;
        logic [1:0]           pr;
        logic [1:0][LOGN-1:0] ph;
        flit_body_t [1:0]     pb;

        bfly_switch #(.HW(LOGN)) u_sw (
            .clk    (clk),
            .rst_n  (rst_n),
            .a_vld  (vld_i[UP]),
            .a_rdy  (rdy_o[UP]),
            .a_hdr  (hdr_i[UP]),
            .a_body (body_i[UP]),
            .b_vld  (vld_i[LO]),
            .b_rdy  (rdy_o[LO]),
            .b_hdr  (hdr_i[LO]),
            .b_body (body_i[LO]),
            .o_vld  (pv),
            .o_rdy  (pr),
            .o_hdr  (ph),
            .o_body (pb)
        );

        // Map the element's two outputs onto the columns of the pair.
        always_comb begin
            pr         = {rdy_i[LO], rdy_i[UP]};
            vld_o[UP]  = pv[0];
            vld_o[LO]  = pv[1];
            hdr_o[UP]  = ph[0];
            hdr_o[LO]  = ph[1];
            body_o[UP] = pb[0];
            body_o[LO] = pb[1];
        end
    end
endmodule

// File: rtl/bfly_router.sv
// Top of the butterfly router: LOGN ranks of 2x2 elements between flat
// per-column ports. NPORTS must be a power of two; the header width and
// the rank count both equal log2(NPORTS). Latency is one cycle per rank.
module bfly_router
    import bfly_pkg::*;
#(
    parameter int NPORTS = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NPORTS-1:0]                 in_valid,
    output logic [NPORTS-1:0]                 in_ready,
    input  logic [NPORTS*$clog2(NPORTS)-1:0]  in_dest,
    input  logic [NPORTS*PAY_W-1:0]           in_payload,
    input  logic [NPORTS*SUM_W-1:0]           in_csum,
    output logic [NPORTS-1:0]                 out_valid,
    input  logic [NPORTS-1:0]                 out_ready,
    output logic [NPORTS*PAY_W-1:0]           out_payload,
    output logic [NPORTS*SUM_W-1:0]           out_csum
);
    localparam int LOGN = $clog2(NPORTS);

    logic [NPORTS-1:0]            vld [LOGN+1];
    logic [NPORTS-1:0]            rdy [LOGN+1];
    logic [NPORTS-1:0][LOGN-1:0]  hdr [LOGN+1];
    flit_body_t [NPORTS-1:0]      body [LOGN+1];
    logic [NPORTS*LOGN-1:0]       spent_hdr;

    // Unpack the flat input ports into rank-0 columns and pack the outputs.
    always_comb begin
        vld[0]      = in_valid;
        in_ready    = rdy[0];
        rdy[LOGN]   = out_ready;
        out_valid   = vld[LOGN];
        for (int p = 0; p < NPORTS; p++) begin
            hdr[0][p]                  = in_dest[p*LOGN +: LOGN];
            body[0][p].pay             = in_payload[p*PAY_W +: PAY_W];
            body[0][p].sum             = in_csum[p*SUM_W +: SUM_W];
            out_payload[p*PAY_W +: PAY_W] = body[LOGN][p].pay;
            out_csum[p*SUM_W +: SUM_W]    = body[LOGN][p].sum;
            spent_hdr[p*LOGN +: LOGN]     = hdr[LOGN][p];
        end
    end

    for (genvar s = 0; s < LOGN; s++) begin : g_rank
        bfly_rank #(.N(NPORTS), .LOGN(LOGN), .STG(s)) u_rank (
            .clk    (clk),
            .rst_n  (rst_n),
            .vld_i  (vld[s]),
            .rdy_o  (rdy[s]),
            .hdr_i  (hdr[s]),
            .body_i (body[s]),
            .vld_o  (vld[s+1]),
            .rdy_i  (rdy[s+1]),
            .hdr_o  (hdr[s+1]),
            .body_o (body[s+1])
        );
    end
endmodule

// File: rtl/bfly_router_chk.sv
// Checker for bfly_router: output hold under backpressure, exhausted header
// at exit, first-rank priority and an in-flight capacity bound.
module bfly_router_chk #(
    parameter int N  = 8,
    parameter int L  = 3,
    parameter int PW = 16,
    parameter int SW = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic [N-1:0]   in_valid,
    input logic [N-1:0]   in_ready,
    input logic [N*L-1:0] in_dest,
    input logic [N-1:0]   out_valid,
    input logic [N-1:0]   out_ready,
    input logic [N*PW-1:0] out_payload,
    input logic [N*SW-1:0] out_csum,
    input logic [N*L-1:0] spent_hdr
);
    int inflight;

    // Running count of packets accepted but not yet delivered.
    always_ff @(posedge clk) begin
        if (!rst_n) inflight <= 0;
        else inflight <= inflight + $countones(in_valid & in_ready)
                                  - $countones(out_valid & out_ready);
    end

    // R2: never more packets inside than there are output registers.
    a_r2_capacity: assert property (@(posedge clk) disable iff (!rst_n)
        inflight <= N * L);

    for (genvar k = 0; k < N; k++) begin : g_port
        // R7: a stalled output keeps its packet stable.
        a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[k] && !out_ready[k] |=> out_valid[k]
                && $stable(out_payload[k*PW +: PW]) && $stable(out_csum[k*SW +: SW]));

        // R4: every header bit has been consumed at exit.
        a_r4_header_spent: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[k] |-> spent_hdr[k*L +: L] == '0);
    end

    for (genvar j = 0; j < N / 2; j++) begin : g_pair
        // R5: upper input of a first-rank pair wins a same-direction clash.
        a_r5_upper_wins: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid[j] && in_valid[j + N/2]
                && (in_dest[j*L + L-1] == in_dest[(j + N/2)*L + L-1])
            |-> !in_ready[j + N/2]);
    end
endmodule

bind bfly_router bfly_router_chk #(
    .N  (NPORTS),
    .L  ($clog2(NPORTS)),
    .PW (bfly_pkg::PAY_W),
    .SW (bfly_pkg::SUM_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_dest     (in_dest),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_payload (out_payload),
    .out_csum    (out_csum),
    .spent_hdr   (spent_hdr)
);

// File: tb/bfly_router_test.sv
module bfly_router_test;
    localparam int N = 8;
    localparam int L = 3;
    localparam int MAXT = 4096;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0]     in_valid, in_ready, out_valid, out_ready;
    logic [N*L-1:0]   in_dest;
    logic [N*16-1:0]  in_payload, out_payload;
    logic [N*8-1:0]   in_csum, out_csum;

    logic [N-1:0] drv_vld;
    logic [L-1:0] drv_dest [N];
    logic [15:0]  drv_pay [N];
    logic [7:0]   drv_sum [N];
    int           drv_tag [N];

    int exp_dest [MAXT];
    logic [15:0] exp_pay [MAXT];
    logic [7:0]  exp_sum [MAXT];
    int acc_cyc [MAXT];
    int arr_cyc [MAXT];
    bit seen [MAXT];
    bit lat_chk [MAXT];

    int ntags = 0, delivered = 0, cyc = 0;
    int checks = 0, errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    bfly_router #(.NPORTS(N)) uut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_dest(in_dest),
        .in_payload(in_payload), .in_csum(in_csum),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_payload(out_payload), .out_csum(out_csum)
    );

    always_comb begin
        in_valid = drv_vld;
        for (int p = 0; p < N; p++) begin
            in_dest[p*L +: L]     = drv_dest[p];
            in_payload[p*16 +: 16] = drv_pay[p];
            in_csum[p*8 +: 8]     = drv_sum[p];
        end
    end

    function automatic logic [7:0] byte_sum(input logic [15:0] w);
        return w[15:8] + w[7:0];
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic new_pkt(input int p, input int d, input bit bad, input bit lat);
        int t;
        t = ntags++;
        exp_dest[t] = d;
        exp_pay[t]  = {t[11:0], 4'($urandom % 16)};
        exp_sum[t]  = byte_sum(exp_pay[t]) ^ (bad ? 8'hFF : 8'h00);
        lat_chk[t]  = lat;
        arr_cyc[t]  = -1;
        drv_vld[p]  = 1'b1;
        drv_dest[p] = L'(d);
        drv_pay[p]  = exp_pay[t];
        drv_sum[p]  = exp_sum[t];
        drv_tag[p]  = t;
    endtask

    task automatic check_out(input int p);
        logic [15:0] pay;
        int t;
        pay = out_payload[p*16 +: 16];
        t = int'(pay[15:4]);
        if (t >= ntags || seen[t]) begin
            check(0, "R2", "unexpected or repeated packet tag", t, ntags);
            return;
        end
        seen[t] = 1;
        arr_cyc[t] = cyc;
        delivered++;
        check(p == exp_dest[t], "R4", "exit port", p, exp_dest[t]);
        check(pay == exp_pay[t] && out_csum[p*8 +: 8] == exp_sum[t], "R2",
              "payload/csum", int'({pay, out_csum[p*8 +: 8]}),
              int'({exp_pay[t], exp_sum[t]}));
        if (lat_chk[t])
            check(cyc - acc_cyc[t] == L, "R3", "latency", cyc - acc_cyc[t], L);
    endtask

    task automatic step();
        bit [N-1:0] took;
        @(negedge clk);
        took = '0;
        for (int p = 0; p < N; p++)
            if (drv_vld[p] && in_ready[p] && rst_n) begin
                acc_cyc[drv_tag[p]] = cyc;
                took[p] = 1'b1;
            end
        for (int p = 0; p < N; p++)
            if (out_valid[p] && out_ready[p]) check_out(p);
        @(posedge clk);
        #1;
        for (int p = 0; p < N; p++) if (took[p]) drv_vld[p] = 1'b0;
        cyc++;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog: cycles %0d expected below %0d", 150000, 150000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int ta, tb;
        drv_vld = '0;
        out_ready = '1;
        for (int p = 0; p < N; p++) begin
            drv_dest[p] = '0; drv_pay[p] = '0; drv_sum[p] = '0; drv_tag[p] = 0;
        end
        for (int t = 0; t < MAXT; t++) begin
            seen[t] = 0; lat_chk[t] = 0; arr_cyc[t] = -1; acc_cyc[t] = 0;
        end
        void'($urandom(32'h5EED_0042));

        // R1: outputs idle during and after reset
        repeat (3) begin
            step();
            check(out_valid == '0, "R1", "out_valid in reset", int'(out_valid), 0);
        end
        rst_n = 1'b1;
        repeat (3) begin
            step();
            check(out_valid == '0, "R1", "out_valid after reset", int'(out_valid), 0);
        end

        // R2 R3 R4: every source/destination pair alone
        for (int s = 0; s < N; s++)
            for (int d = 0; d < N; d++) begin
                new_pkt(s, d, 0, 1);
                repeat (5) step();
            end

        // R5: columns 0 and 4 both head for the MSB-0 side
        new_pkt(0, 0, 0, 1);
        ta = ntags - 1;
        new_pkt(4, 1, 0, 1);
        tb = ntags - 1;
        #2;
        check(in_ready[0] == 1'b1, "R5", "upper ready", int'(in_ready[0]), 1);
        check(in_ready[4] == 1'b0, "R5", "lower stalled", int'(in_ready[4]), 0);
        repeat (6) step();
        check(arr_cyc[tb] - arr_cyc[ta] == 1, "R5", "loser one cycle later",
              arr_cyc[tb] - arr_cyc[ta], 1);

        // R6: same pair, opposite directions
        new_pkt(0, 0, 0, 1);
        ta = ntags - 1;
        new_pkt(4, 7, 0, 1);
        tb = ntags - 1;
        #2;
        check(in_ready[0] && in_ready[4], "R6", "both ready", int'({in_ready[4], in_ready[0]}), 3);
        repeat (6) step();
        check(arr_cyc[ta] == arr_cyc[tb] && arr_cyc[ta] >= 0, "R6", "same arrival",
              arr_cyc[tb], arr_cyc[ta]);

        // R8: corrupted trailer passes unchanged
        new_pkt(6, 5, 1, 1);
        ta = ntags - 1;
        repeat (6) step();
        check(seen[ta], "R8", "bad-trailer packet delivered", int'(seen[ta]), 1);

        // R7: stalled output holds its packet
        out_ready[3] = 1'b0;
        new_pkt(1, 3, 0, 0);
        ta = ntags - 1;
        repeat (5) step();
        begin
            logic [15:0] held;
            held = out_payload[3*16 +: 16];
            check(out_valid[3] == 1'b1, "R7", "stalled valid", int'(out_valid[3]), 1);
            repeat (8) begin
                step();
                check(out_valid[3] && out_payload[3*16 +: 16] == held, "R7", "held payload",
                      int'(out_payload[3*16 +: 16]), int'(held));
            end
        end
        out_ready[3] = 1'b1;
        repeat (3) step();
        check(seen[ta], "R7", "released packet delivered", int'(seen[ta]), 1);

        // R2 R7: dense random traffic with random sink stalls
        for (int c = 0; c < 2500; c++) begin
            for (int p = 0; p < N; p++)
                if (!drv_vld[p] && ntags < MAXT - 16 && ($urandom % 3) == 0)
                    new_pkt(p, int'($urandom % N), 0, 0);
            for (int p = 0; p < N; p++) out_ready[p] = ($urandom % 4) != 0;
            step();
        end
        out_ready = '1;
        for (int c = 0; c < 200 && (delivered != ntags || drv_vld != '0); c++) step();
        check(delivered == ntags, "R2", "all packets delivered", delivered, ntags);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule